// File: doc/BRIEF.md
# Spectrum Bar Height Processor

This block turns one frame of 32 eight-bit frequency magnitudes into drawing instructions for a 160 by 200 monochrome bar display. Once a frame of magnitudes sits in an external byte buffer, a strobe starts the block. It reads the buffer through a synchronous read port. It ignores the lowest bin because that bin carries mostly the DC level. It then produces one bar per clock for the remaining 31 bins, from the lowest frequency on the left to the highest on the right. For each bar it gives the left and right pixel column and the top row, so a pixel writer can fill the column span from that row down to the bottom row.

Each magnitude goes through one of two scalings. The linear scaling uses the byte as the height. The logarithmic scaling uses a table that is computed when the design is elaborated. The result is then compared with the height the same bar showed in the previous frame. A larger value is shown at once. Otherwise the old height shrinks by a fraction chosen by the decay setting. This makes falling bars sink smoothly while peaks appear immediately. A pause input makes the block ignore new frames.

Top module: `spectrum_bars`

## Requirements
- R1: An accepted strobe makes the block read buffer addresses 1 to 31 and emit 31 bars on consecutive cycles. The first bar appears two cycles after the edge that accepts the strobe. Bar index i (0 to 30) is computed from buffer address i+1, and the byte at address 0 never affects any output.
- R2: Bar i spans columns 5*i to 5*i+3 (bar_x0, bar_x1): four pixels wide with a one-pixel gap, so the bars cover columns 0 to 153.
- R3: bar_top equals 199 minus bar_height (row 0 at the top, rows increase downward).
- R4: With log_mode=1, the scaled value of byte v is 0 for v<2. For other v it is ln(v)*45-30 truncated to an integer: forced to 0 if negative and limited to 198.
- R5: With log_mode=0, the scaled value is the byte itself, limited to 198.
- R6: bar_height never exceeds 198.
- R7: If the scaled value is greater than the bar's previous height p, it is shown. Otherwise the block shows p - (p >> k), with k=4 for decay_sel=0 (slow), k=3 for 1 (medium), and k=2 for 2 or 3 (fast).
- R8: A strobe that arrives while pause=1 is ignored. No bar and no done pulse follow, and the previous heights stay as they were.
- R9: done pulses for one cycle, one cycle after the last bar. All 31 previous heights change to the values just shown at that same edge.
- R10: log_mode and decay_sel are captured at the edge that accepts the strobe. A strobe that arrives while reads are still being issued is ignored.
- R11: After reset, bar_valid and done are low and every previous height is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| buf_valid | input | 1 | Strobe: a full magnitude buffer is ready |
| rd_data | input | 8 | Byte returned one cycle after rd_addr |
| log_mode | input | 1 | 1 selects logarithmic scaling, 0 linear |
| decay_sel | input | 2 | Decay speed: 0 slow, 1 medium, 2 or 3 fast |
| pause | input | 1 | Ignore new buffers while high |
| rd_addr | output | 5 | Buffer read address |
| bar_valid | output | 1 | Bar outputs are valid this cycle |
| bar_idx | output | 5 | Bar number, 0 at the left |
| bar_x0 | output | 8 | Leftmost column of the bar |
| bar_x1 | output | 8 | Rightmost column of the bar |
| bar_top | output | 8 | Top row of the bar |
| bar_height | output | 8 | Bar height in pixels |
| done | output | 1 | One-cycle pulse after the last bar |

## Verification
The stored previous heights show only at the ports, and only in a later frame. A wrong stored height, a missed update or an update made during a paused strobe is therefore found by the decay values of the following frame. The bench runs frames of all-zero magnitudes after known frames so that every bar depends only on the stored value. An error in read addressing or in the pipeline alignment shows on the first bar of the same frame, because each bar's expected position and height is compared in its own cycle. The bar at address 0 is loaded with its largest value so that any use of it shows up.

// File: rtl/spectrum_bars.sv
module spectrum_bars #(
  parameter int NBINS    = 32,
  parameter int MAG_W    = 8,
  parameter int SCREEN_H = 200,
  parameter int BAR_W    = 4,
  parameter int BAR_GAP  = 1,
  parameter int HMAX     = 198,
  localparam int AW      = $clog2(NBINS),
  localparam int NBARS   = NBINS - 1,
  localparam int PITCH   = BAR_W + BAR_GAP,
  localparam int XW      = $clog2(NBARS * PITCH),
  localparam int YW      = $clog2(SCREEN_H)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             buf_valid,
  input  logic [MAG_W-1:0] rd_data,
  input  logic             log_mode,
  input  logic [1:0]       decay_sel,
  input  logic             pause,
  output logic [AW-1:0]    rd_addr,
  output logic             bar_valid,
  output logic [AW-1:0]    bar_idx,
  output logic [XW-1:0]    bar_x0,
  output logic [XW-1:0]    bar_x1,
  output logic [YW-1:0]    bar_top,
  output logic [YW-1:0]    bar_height,
  output logic             done
);

  typedef logic [YW-1:0] ltab_t [2**MAG_W];

  function automatic ltab_t build_log();
    ltab_t t;
    real   r;
    for (int v = 0; v < 2**MAG_W; v++) begin
      if (v < 2) t[v] = '0;
      else begin
        r = $ln(real'(v)) * 45.0 - 30.0;
        if (r < 0.0)               t[v] = '0;
        else if (r > real'(HMAX))  t[v] = YW'(HMAX);
        else                       t[v] = YW'($rtoi(r));
      end
    end
    return t;
  endfunction

  localparam ltab_t LOG_TAB = build_log();

  logic          busy, rd_pend, last_q, lm_q;
  logic [1:0]    ds_q;
  logic [AW-1:0] issue, pend_bin, bar_i;
  logic [YW-1:0] prev_q [NBARS];
  logic [YW-1:0] next_q [NBARS];
  logic [YW-1:0] lin_h, scaled, pv, decayed, shown;
  logic [2:0]    shamt;

  assign rd_addr = issue;
  assign bar_i   = pend_bin - 1'b1;
  assign lin_h   = (rd_data > MAG_W'(HMAX)) ? YW'(HMAX) : YW'(rd_data);
  assign scaled  = lm_q ? LOG_TAB[rd_data] : lin_h;
  assign shamt   = (ds_q == 2'd0) ? 3'd4 : (ds_q == 2'd1) ? 3'd3 : 3'd2;
  assign pv      = prev_q[bar_i];
  assign decayed = pv - (pv >> shamt);
  assign shown   = (scaled > pv) ? scaled : decayed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      rd_pend    <= 1'b0;
      last_q     <= 1'b0;
      lm_q       <= 1'b0;
      ds_q       <= '0;
      issue      <= '0;
      pend_bin   <= '0;
      bar_valid  <= 1'b0;
      bar_idx    <= '0;
      bar_x0     <= '0;
      bar_x1     <= '0;
      bar_top    <= '0;
      bar_height <= '0;
      done       <= 1'b0;
      for (int i = 0; i < NBARS; i++) begin
        prev_q[i] <= '0;
        next_q[i] <= '0;
      end
    end else begin
      bar_valid <= 1'b0;
      done      <= 1'b0;
      rd_pend   <= busy;
      pend_bin  <= issue;
      if (busy) begin
        if (issue == AW'(NBINS - 1)) busy <= 1'b0;
        else                         issue <= issue + 1'b1;
      end else if (buf_valid && !pause) begin
        busy  <= 1'b1;
        issue <= AW'(1);
        lm_q  <= log_mode;
        ds_q  <= decay_sel;
      end
      if (rd_pend) begin
        bar_valid      <= 1'b1;
        bar_idx        <= bar_i;
        bar_x0         <= XW'(bar_i) * XW'(PITCH);
        bar_x1         <= XW'(bar_i) * XW'(PITCH) + XW'(BAR_W - 1);
        bar_top        <= YW'(SCREEN_H - 1) - shown;
        bar_height     <= shown;
        next_q[bar_i]  <= shown;
        last_q         <= (pend_bin == AW'(NBINS - 1));
      end else begin
        last_q <= 1'b0;
      end
      if (last_q) begin
        done   <= 1'b1;
        prev_q <= next_q;
      end
    end
  end

  p_span_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bar_valid && $past(bar_valid) |-> bar_x0 == $past(bar_x0) + XW'(PITCH));

  p_height_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bar_valid |-> bar_height <= YW'(HMAX));

  p_decay_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bar_valid |-> bar_height >= prev_q[bar_idx] - (prev_q[bar_idx] >> 2));

  p_pause_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && pause |=> !busy);

  p_done_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(bar_valid) && $past(bar_idx) == AW'(NBARS - 1));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/spectrum_bars_bench.sv
module spectrum_bars_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       buf_valid = 1'b0;
  logic [7:0] rd_data = '0;
  logic       log_mode = 1'b0;
  logic [1:0] decay_sel = '0;
  logic       pause = 1'b0;
  logic [4:0] rd_addr, bar_idx;
  logic       bar_valid, done;
  logic [7:0] bar_x0, bar_x1, bar_top, bar_height;

  logic [7:0] mem [32];
  int prev_h [31];
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) rd_data <= mem[rd_addr];

  spectrum_bars u_spectrum_bars (
    .clk(clk), .rst_n(rst_n), .buf_valid(buf_valid), .rd_data(rd_data),
    .log_mode(log_mode), .decay_sel(decay_sel), .pause(pause),
    .rd_addr(rd_addr), .bar_valid(bar_valid), .bar_idx(bar_idx),
    .bar_x0(bar_x0), .bar_x1(bar_x1), .bar_top(bar_top),
    .bar_height(bar_height), .done(done));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int log_h(input int v);
    real r;
    if (v < 2) return 0;
    r = $ln(real'(v)) * 45.0 - 30.0;
    if (r < 0.0) return 0;
    if (r > 198.0) return 198;
    return $rtoi(r);
  endfunction

  task automatic run_frame(input bit lm, input logic [1:0] ds, input bit pz, input int mid);
    int exp_h [31];
    int sh;
    sh = (ds == 2'd0) ? 4 : (ds == 2'd1) ? 3 : 2;
    for (int i = 0; i < 31; i++) begin
      int s;
      s = lm ? log_h(mem[i+1]) : ((mem[i+1] > 198) ? 198 : int'(mem[i+1]));
      exp_h[i] = (s > prev_h[i]) ? s : prev_h[i] - (prev_h[i] >> sh);
    end
    @(negedge clk);
    buf_valid = 1'b1; log_mode = lm; decay_sel = ds; pause = pz;
    @(negedge clk);
    buf_valid = 1'b0;
    for (int k = 1; k <= 34; k++) begin
      @(negedge clk);
      buf_valid = 1'b0;
      if (k == mid) begin
        buf_valid = 1'b1; log_mode = ~lm; decay_sel = ~ds; pause = 1'b0;
      end
      if (!pz && k >= 2 && k <= 32) begin
        int b;
        b = k - 2;
        check(bar_valid == 1'b1, "R1 bar_valid", int'(bar_valid), 1);
        check(bar_idx == 5'(b), "R1 bar_idx", int'(bar_idx), b);
        check(bar_x0 == 8'(5*b) && bar_x1 == 8'(5*b+3), "R2 x span", int'(bar_x0), 5*b);
        check(int'(bar_height) == exp_h[b], lm ? "R4 R7 log height" : "R5 R7 lin height",
              int'(bar_height), exp_h[b]);
        check(int'(bar_top) == 199 - exp_h[b], "R3 top", int'(bar_top), 199 - exp_h[b]);
        check(bar_height <= 8'd198, "R6 cap", int'(bar_height), 198);
      end else begin
        check(bar_valid == 1'b0, pz ? "R8 no bar while paused" : "R1 R10 no extra bar",
              int'(bar_valid), 0);
      end
      check(done == (!pz && k == 33), "R9 done timing", int'(done), int'(!pz && k == 33));
    end
    pause = 1'b0;
    if (!pz) for (int i = 0; i < 31; i++) prev_h[i] = exp_h[i];
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 31; i++) prev_h[i] = 0;
    for (int i = 0; i < 32; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    check(bar_valid == 1'b0 && done == 1'b0, "R11 reset outputs", int'(bar_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(bar_valid == 1'b0, "R11 idle after reset", int'(bar_valid), 0);

    // R11: zeros with medium decay reveal all-zero stored heights
    run_frame(1'b0, 2'd1, 1'b0, 0);
    // R5: varied bytes including values above the cap; bin 0 at max (R1)
    for (int i = 0; i < 32; i++) mem[i] = 8'((i * 37 + 11) % 256);
    mem[0] = 8'd255; mem[5] = 8'd255; mem[6] = 8'd199;
    run_frame(1'b0, 2'd1, 1'b0, 0);
    // R7 slow decay with some rising bars
    for (int i = 0; i < 32; i++) mem[i] = (i % 4 == 0) ? 8'd60 : 8'd0;
    mem[0] = 8'd255;
    run_frame(1'b0, 2'd0, 1'b0, 0);
    // R7 fast decay, then code 3
    for (int i = 1; i < 32; i++) mem[i] = 8'd0;
    run_frame(1'b0, 2'd2, 1'b0, 0);
    run_frame(1'b0, 2'd3, 1'b0, 0);
    // R4: logarithmic table corner values
    for (int i = 1; i < 32; i++) mem[i] = 8'(i * 8 + 7);
    mem[1] = 8'd0; mem[2] = 8'd1; mem[3] = 8'd2; mem[4] = 8'd3; mem[31] = 8'd255;
    run_frame(1'b1, 2'd1, 1'b0, 0);
    // R8: paused strobe with large values must change nothing
    for (int i = 1; i < 32; i++) mem[i] = 8'd200;
    run_frame(1'b0, 2'd2, 1'b1, 0);
    for (int i = 1; i < 32; i++) mem[i] = 8'd0;
    run_frame(1'b0, 2'd1, 1'b0, 0);
    // R10: strobe during the frame with other modes is ignored
    for (int i = 1; i < 32; i++) mem[i] = 8'(100 + i);
    run_frame(1'b0, 2'd0, 1'b0, 10);
    for (int i = 1; i < 32; i++) mem[i] = 8'd0;
    run_frame(1'b0, 2'd0, 1'b0, 5);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule